// File: doc/BRIEF.md
# Masked Register Command Stream Parser

This block takes a stream of 32-bit command words and turns it into masked writes on a local register file. A command is a value word followed by a header word. The header names the target register, gives a 4-bit byte-lane mask, a count of extra words that follow, and a flag that picks between two burst styles. In the first burst style every extra word goes to the same register. In the second each extra word goes to the next register in turn.

Every write is a read-modify-write. Byte lanes whose mask bit is set take the new data, and the other lanes keep the value the register already held. Each committed write is reported for one cycle on a strobe that carries the register id and the merged value, so that downstream logic can react to registers with side effects. The stream side is a plain valid/ready handshake. The block drops ready for exactly one cycle per write while that write commits.

Top module: `regcmd_parser`

## Requirements
- R1: Mask bit b enables byte lane b of the register, so bit 0 controls data bits 7:0 and bit 3 controls bits 31:24. For example, mask 4'b0101 gives a lane pattern of 32'h00FF00FF.
- R2: A write keeps the previous register bits in lanes whose mask bit is 0 and takes the incoming word in lanes whose mask bit is 1.
- R3: A command starts with one value word. The header word follows it, and the first write of the command uses that value word.
- R4: After the first write, exactly the number of extra words given in the header are consumed. Each of them is written with the header's mask, and a count of 0 ends the command after the first write.
- R5: When the group flag is 1, extra word k (counting from 0) is written to register id+k+1.
- R6: When the group flag is 0, every extra word is written to the header's register id.
- R7: The header field layout is: register id in bits 15:0, mask in bits 19:16, extra count in bits 27:20 and group flag in bit 31. Bits 30:28 are ignored.
- R8: A write whose target id is NUM_REGS or higher has no effect. It produces no strobe and changes no register, but it still consumes its word.
- R9: Each write to an implemented register raises wrStrobe for exactly one cycle, with wrId set to the register id and wrData set to the merged value now held in that register.
- R10: inReady is low for exactly the one cycle after a header word or an extra word is accepted, and it is high in every other cycle.
- R11: After reset all registers hold 0, wrStrobe is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A command word is offered |
| inWord | input | 32 | Command word |
| inReady | output | 1 | Block accepts a word this cycle |
| wrStrobe | output | 1 | One-cycle pulse per committed write |
| wrId | output | ID_W | Register id of the committed write |
| wrData | output | 32 | Merged value written to the register |

## Verification
The assertions check on every cycle that a strobe never carries an id outside the implemented range, that strobes never occur back to back, that every strobe follows a stalled cycle, and that ready is high again once a strobe appears. Lane merging, the order of value and header words, the burst count and the two addressing styles only show up as data. The bench's scenarios compare every strobe against a shadow model of the register file, including partial masks on registers that already hold data and bursts that run past the last implemented register.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  localparam int DATA_W  = 32;
  localparam int BYTES   = DATA_W / 8;
  localparam int HID_LSB = 0;
  localparam int HID_W   = 16;
  localparam int HMSK_LSB = 16;
  localparam int HLEN_LSB = 20;
  localparam int HLEN_W  = 8;
  localparam int HGRP_BIT = 31;

  typedef struct packed {
    logic loadValue;
    logic loadHeader;
    logic loadExtra;
    logic commit;
  } ctrlStrobe_t;
endpackage

// File: rtl/regcmd_ctrl.sv
module regcmd_ctrl
  import regcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        lastWord,
  output logic        inReady,
  output ctrlStrobe_t st
);
  typedef enum logic [1:0] {S_VALUE, S_HEADER, S_COMMIT, S_EXTRA} state_t;
  state_t state, stateNext;
  logic accept;

  assign inReady = (state != S_COMMIT);
  assign accept  = inValid && inReady;

  always_comb begin
    stateNext = state;
    st = '0;
    unique case (state)
      S_VALUE:  if (accept) begin st.loadValue = 1'b1; stateNext = S_HEADER; end
      S_HEADER: if (accept) begin st.loadHeader = 1'b1; stateNext = S_COMMIT; end
      S_EXTRA:  if (accept) begin st.loadExtra = 1'b1; stateNext = S_COMMIT; end
      S_COMMIT: begin
        st.commit = 1'b1;
        stateNext = lastWord ? S_VALUE : S_EXTRA;
      end
      default: stateNext = S_VALUE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_VALUE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/regcmd_dp.sv
module regcmd_dp
  import regcmd_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int ID_W     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inWord,
  input  ctrlStrobe_t       st,
  output logic              lastWord,
  output logic              wrStrobe,
  output logic [ID_W-1:0]   wrId,
  output logic [DATA_W-1:0] wrData
);
  localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] dataReg;
  logic [HID_W-1:0]  idReg;
  logic [BYTES-1:0]  maskReg;
  logic [HLEN_W-1:0] remaining;
  logic              groupReg;
  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] merged;
  logic              inRange;
  logic [ADDR_W-1:0] idx;
  logic              unusedHdr;

  assign unusedHdr = &{1'b0, inWord[30:28]};

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign laneMask[8*b +: 8] = {8{maskReg[b]}};
  end

  assign inRange  = (idReg < HID_W'(NUM_REGS));
  assign idx      = idReg[ADDR_W-1:0];
  assign merged   = (regFile[idx] & ~laneMask) | (dataReg & laneMask);
  assign lastWord = (remaining == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
      dataReg   <= '0;
      idReg     <= '0;
      maskReg   <= '0;
      remaining <= '0;
      groupReg  <= 1'b0;
      wrStrobe  <= 1'b0;
      wrId      <= '0;
      wrData    <= '0;
    end else begin
      wrStrobe <= 1'b0;
      if (st.loadValue) dataReg <= inWord;
      if (st.loadHeader) begin
        idReg     <= inWord[HID_LSB +: HID_W];
        maskReg   <= inWord[HMSK_LSB +: BYTES];
        remaining <= inWord[HLEN_LSB +: HLEN_W];
        groupReg  <= inWord[HGRP_BIT];
      end
      if (st.loadExtra) begin
        dataReg   <= inWord;
        remaining <= remaining - 1'b1;
        if (groupReg) idReg <= idReg + 1'b1;
      end
      if (st.commit && inRange) begin
        regFile[idx] <= merged;
        wrStrobe     <= 1'b1;
        wrId         <= idReg[ID_W-1:0];
        wrData       <= merged;
      end
    end
  end
endmodule

// File: rtl/regcmd_parser.sv
module regcmd_parser
  import regcmd_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int ID_W     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inWord,
  output logic              inReady,
  output logic              wrStrobe,
  output logic [ID_W-1:0]   wrId,
  output logic [DATA_W-1:0] wrData
);
  ctrlStrobe_t st;
  logic lastWord;

  regcmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .lastWord(lastWord), .inReady(inReady), .st(st)
  );

  regcmd_dp #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .inWord(inWord), .st(st),
    .lastWord(lastWord), .wrStrobe(wrStrobe), .wrId(wrId), .wrData(wrData)
  );
endmodule

// File: rtl/regcmd_chk.sv
module regcmd_chk #(
  parameter int NUM_REGS = 64,
  parameter int ID_W     = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic            inReady,
  input logic            wrStrobe,
  input logic [ID_W-1:0] wrId
);
  AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (int'(wrId) < NUM_REGS)); // R8

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe); // R9

  AST_STALL_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> $past(!inReady)); // R10

  AST_READY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> inReady); // R10

  AST_NO_DOUBLE_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> inReady); // R10
endmodule

bind regcmd_parser regcmd_chk #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .wrStrobe(wrStrobe), .wrId(wrId)
);

// File: tb/tb_regcmd_parser.sv
`timescale 1ns/1ps
module tb_regcmd_parser;
  localparam int NUM_REGS = 64;
  localparam int ID_W     = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic inReady, wrStrobe;
  logic [ID_W-1:0] wrId;
  logic [31:0] wrData;

  int errors = 0;
  int checks = 0;

  logic [31:0] shadow [NUM_REGS];
  logic [15:0] expId   [1024];
  logic [31:0] expData [1024];
  int expWr = 0;
  int expRd = 0;
  logic prevStrobe = 1'b0;

  always #10 clk = ~clk;

  regcmd_parser #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .inReady(inReady), .wrStrobe(wrStrobe), .wrId(wrId), .wrData(wrData)
  );

  function automatic logic [31:0] lanes(input logic [3:0] m);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = {8{m[b]}};
    return r;
  endfunction

  function automatic logic [31:0] mkHeader(input logic [15:0] id, input logic [3:0] m,
                                           input logic [7:0] len, input logic grp);
    return {grp, 3'b101, len, m, id};
  endfunction

  task automatic modelWrite(input logic [15:0] id, input logic [3:0] m, input logic [31:0] d);
    if (int'(id) < NUM_REGS) begin
      shadow[id] = (shadow[id] & ~lanes(m)) | (d & lanes(m));
      expId[expWr]   = id;
      expData[expWr] = shadow[id];
      expWr++;
    end
  endtask

  task automatic sendWord(input logic [31:0] w, input logic stall);
    @(negedge clk);
    inValid = 1'b1;
    inWord  = w;
    forever begin
      if (inReady) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    inWord  = $urandom;
    if (stall) begin
      checks++;
      if (inReady !== 1'b0) begin
        errors++;
        $display("FAIL R10 inReady during commit: actual=%b expected=0", inReady);
      end
    end
  endtask

  task automatic sendCmd(input logic [31:0] val, input logic [15:0] id, input logic [3:0] m,
                         input int len, input logic grp);
    logic [31:0] w;
    sendWord(val, 1'b0);
    modelWrite(id, m, val);
    sendWord(mkHeader(id, m, 8'(len), grp), 1'b1);
    for (int k = 0; k < len; k++) begin
      w = $urandom;
      modelWrite(grp ? 16'(id + 16'(k) + 16'd1) : id, m, w);
      sendWord(w, 1'b1);
    end
    repeat (3) @(negedge clk);
  endtask

  // Compares every strobe against the shadow model: R1 R2 R3 R4 R5 R6 R7 R9
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStrobe && wrStrobe) begin
        checks++;
        errors++;
        $display("FAIL R9 strobe held two cycles: actual=1 expected=0");
      end
      if (wrStrobe) begin
        checks++;
        if (expRd >= expWr) begin
          errors++;
          $display("FAIL R8 unexpected write: actual id=%0d data=%h expected none", wrId, wrData);
        end else begin
          if (wrId !== expId[expRd][ID_W-1:0] || wrData !== expData[expRd]) begin
            errors++;
            $display("FAIL R2 write mismatch: actual id=%0d data=%h expected id=%0d data=%h",
                     wrId, wrData, expId[expRd], expData[expRd]);
          end
          expRd++;
        end
      end
    end
    prevStrobe = wrStrobe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NUM_REGS; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;  // R11 reset state
    if (inReady !== 1'b1 || wrStrobe !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset state: actual ready=%b strobe=%b expected ready=1 strobe=0",
               inReady, wrStrobe);
    end

    // R1 R11: lane pattern 0101 on a zero register gives 0x00BB00DD
    sendCmd(32'hAABBCCDD, 16'd3, 4'b0101, 0, 1'b0);
    // R2: other lanes merge over old contents -> 0x11BB33DD
    sendCmd(32'h11223344, 16'd3, 4'b1010, 0, 1'b0);
    // R3 R7: mask 1000 only touches bits 31:24
    sendCmd(32'h5A000000, 16'd3, 4'b1000, 0, 1'b0);
    // R5: grouped burst walks ids 5..8
    sendCmd(32'h01010101, 16'd5, 4'b1111, 3, 1'b1);
    // R6: ungrouped burst stays on id 9
    sendCmd(32'h02020202, 16'd9, 4'b0011, 2, 1'b0);
    // R4: longer burst with partial mask
    sendCmd(32'h0F0F0F0F, 16'd20, 4'b0110, 20, 1'b0);
    // R8: id beyond range, and ids with upper header bits set
    sendCmd(32'hDEADBEEF, 16'd70, 4'b1111, 2, 1'b0);
    sendCmd(32'hDEADBEEF, 16'h0403, 4'b1111, 0, 1'b0);
    // R8 R5: grouped burst runs past the last register (62,63 kept; 64,65 dropped)
    sendCmd(32'hCAFEF00D, 16'd62, 4'b1111, 3, 1'b1);
    // R2 R8: confirm register 6 untouched by the id-70 write
    sendCmd(32'h00000000, 16'd6, 4'b0000, 0, 1'b0);

    for (int n = 0; n < 60; n++) begin
      sendCmd($urandom, 16'($urandom_range(0, 70)), 4'($urandom), $urandom_range(0, 5),
              1'($urandom));
    end

    repeat (5) @(negedge clk);
    checks++;  // R4 every modelled write appeared
    if (expRd != expWr) begin
      errors++;
      $display("FAIL R4 write count: actual=%0d expected=%0d", expRd, expWr);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule